// File: doc/BRIEF.md
# Audio Receive Sample FIFO with Word Packing

This block is the storage stage on the receive side of a serial audio port. The deserializer hands it one left/right sample pair per strobe. A processor or DMA engine drains it through a 32-bit read port. The shape of each word on that port depends on the packing mode:

- **Dual stereo:** one sample per read, left first, then right.
- **16-bit compact:** both channels in one word.
- **8-bit compact:** both channels in the low half-word.
- **Mono:** the left sample alone.

Every stored entry is a pair, including in mono. The occupancy is therefore reported in half-pair units, so each entry adds two.

Small control registers set the mode, a request threshold and a request mask. When the occupancy is strictly above the threshold and the mask is set, a service request line is raised. A rising receive enable arms the mask. While the receiver is off, incoming pairs are ignored. A pair that arrives while all slots are taken is dropped, and a sticky overflow flag records the loss.

Top module: `audio_rx_pack_fifo`

## Requirements
- R1: In dual mode (mode field compact=0, mono=0), consecutive reads of one entry return the left sample and then the right sample, each zero-extended to 32 bits.
- R2: In 16-bit compact mode (config bit 0 set, bits 1 and 2 clear), one read returns left in bits 15:0 and right in bits 31:16, and pops a whole entry.
- R3: In 8-bit compact mode (config bits 0 and 1 set, bit 2 clear), one read returns left in bits 7:0 and right in bits 15:8, with bits 31:16 zero.
- R4: In mono mode (config bit 2 set, which overrides bits 0 and 1), one read returns the left sample, and each entry adds 2 to the level.
- R5: The level equals twice the number of stored entries, up to 16 for 8 entries. In dual mode it is one less after the left half of the head entry has been read, which makes the level odd.
- R6: The service request is high exactly when the mask is 1 and the level is strictly greater than the limit with bit 0 taken as 0. A limit of 16 never requests.
- R7: The limit read-back always shows bit 0 as 1. Bits 4:1 show the last written bits 4:1. The reset limit is 0.
- R8: A rising receive enable sets the mask to 1. Pairs presented while the enable is low leave the level unchanged.
- R9: While the level is 0 the read data is zero, and a read leaves the level at 0.
- R10: A pair presented while the level is 16 is dropped and sets the overflow flag, which stays set until reset.
- R11: A config write (select 0) replaces the whole mode from write bits 2:0 (bit 0 compact, bit 1 8-bit select, bit 2 mono). Bit 1 alone selects dual, and other bits are ignored. Limit is select 1 (bits 4:1), and mask is select 2 (bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable; capture only while high, rising edge arms mask |
| in_valid | input | 1 | Sample pair strobe from the deserializer |
| in_left | input | SW | Left (or mono) sample |
| in_right | input | SW | Right sample |
| rd_pop | input | 1 | Read strobe; consumes what rd_data shows |
| rd_data | output | 32 | Packed word of the head entry, zero when empty |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 2 | Control register select: 0 mode, 1 limit, 2 mask |
| reg_wdata | input | 32 | Control register write data |
| level_o | output | LVL_W | Occupancy in half-pair units |
| limit_o | output | LVL_W | Limit read-back, bit 0 forced to 1 |
| mask_o | output | 1 | Service request mask |
| svc_req | output | 1 | Service request |
| overflow | output | 1 | Sticky dropped-pair flag |

## Verification
A wrong read or write pointer shows up on `rd_data` at the very next read, because the bench gives every entry in every mode a distinct arithmetic value. A stale half-read flag shows up as an odd `level_o` or as a repeated left sample within one read. A count error moves `level_o` in the same cycle as the push or pop that caused it. Any off-by-one in the threshold shows up as a wrong `svc_req` somewhere in the full sweep of each even limit against every level from 16 down to 0.

// File: rtl/arxf_pkg.sv
// Shared types for the audio receive FIFO: packing modes, register
// selects and configuration bit positions.
package arxf_pkg;

    typedef enum logic [1:0] {
        MD_DUAL  = 2'd0,
        MD_CMP16 = 2'd1,
        MD_CMP8  = 2'd2,
        MD_MONO  = 2'd3
    } rx_mode_e;

    localparam int CFG_CMP_BIT  = 0;
    localparam int CFG_C8_BIT   = 1;
    localparam int CFG_MONO_BIT = 2;

    localparam logic [1:0] SEL_CFG   = 2'd0;
    localparam logic [1:0] SEL_LIMIT = 2'd1;
    localparam logic [1:0] SEL_MASK  = 2'd2;

    // Mono wins over compact; the 8-bit select only matters when compact is set.
    function automatic rx_mode_e decode_mode(input logic [2:0] b);
        if (b[CFG_MONO_BIT])
            return MD_MONO;
        else if (b[CFG_CMP_BIT])
            return b[CFG_C8_BIT] ? MD_CMP8 : MD_CMP16;
        else
            return MD_DUAL;
    endfunction

endpackage

// File: rtl/arxf_pair_store.sv
// Circular store of left/right sample pairs.
// Assumes: the caller never pushes while full and never pops while empty.
module arxf_pair_store #(
    parameter int PAIRS = 8,
    parameter int SW    = 32,
    localparam int PTR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int CNT_W = $clog2(PAIRS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [SW-1:0]    push_l_i,
    input  logic [SW-1:0]    push_r_i,
    input  logic             pop_i,
    output logic [SW-1:0]    head_l_o,
    output logic [SW-1:0]    head_r_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             empty_o
);

    logic [SW-1:0]    mem_l [PAIRS];
    logic [SW-1:0]    mem_r [PAIRS];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(PAIRS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Sample storage: written at the tail, no reset needed.
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_l[wr_ptr] <= push_l_i;
            mem_r[wr_ptr] <= push_r_i;
        end
    end

    // Pointer and entry count maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_i) wr_ptr <= ptr_next(wr_ptr);
            if (pop_i)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Head entry and occupancy flags.
    always_comb begin
        head_l_o = mem_l[rd_ptr];
        head_r_o = mem_r[rd_ptr];
        cnt_o    = cnt;
        full_o   = (cnt == CNT_W'(PAIRS));
        empty_o  = (cnt == '0);
    end

endmodule

// File: rtl/arxf_packer.sv
// Forms the 32-bit read word from the head pair according to the mode.
// Assumes: 16 <= SW <= 32; returns zero when the store is empty.
module arxf_packer
    import arxf_pkg::*;
#(
    parameter int SW = 32
) (
    input  rx_mode_e       mode_i,
    input  logic           half_i,
    input  logic           empty_i,
    input  logic [SW-1:0]  head_l_i,
    input  logic [SW-1:0]  head_r_i,
    output logic [31:0]    data_o
);

    logic [31:0] l32;
    logic [31:0] r32;

    // Mode-dependent word layout.
    always_comb begin
        l32 = 32'(head_l_i);
        r32 = 32'(head_r_i);
        if (empty_i) begin
            data_o = '0;
        end else begin
            case (mode_i)
                MD_DUAL:  data_o = half_i ? r32 : l32;
                MD_CMP16: data_o = {r32[15:0], l32[15:0]};
                MD_CMP8:  data_o = {16'h0000, r32[7:0], l32[7:0]};
                default:  data_o = l32;
            endcase
        end
    end

endmodule

// File: rtl/arxf_ctl.sv
// Control registers (mode, limit, mask) and the service-request compare.
// Assumes: level_i is in half-pair units; limit bit 0 is not stored.
module arxf_ctl
    import arxf_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic [LVL_W-1:0] level_i,
    output rx_mode_e         mode_o,
    output logic [LVL_W-1:0] limit_o,
    output logic             mask_o,
    output logic             svc_o
);

    logic             en_q;
    logic [LVL_W-2:0] lim_hi;
    logic             mask_q;
    rx_mode_e         mode_q;

    // Register writes; a rising enable arms the mask over any mask write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lim_hi <= '0;
            mask_q <= 1'b0;
            mode_q <= MD_DUAL;
        end else begin
            en_q <= rx_en;
            if (reg_wr && reg_sel == SEL_CFG)
                mode_q <= decode_mode(reg_wdata[2:0]);
            if (reg_wr && reg_sel == SEL_LIMIT)
                lim_hi <= reg_wdata[LVL_W-1:1];
            if (rx_en && !en_q)
                mask_q <= 1'b1;
            else if (reg_wr && reg_sel == SEL_MASK)
                mask_q <= reg_wdata[0];
        end
    end

    // Read-back and strict greater-than request compare.
    always_comb begin
        mode_o  = mode_q;
        mask_o  = mask_q;
        limit_o = {lim_hi, 1'b1};
        svc_o   = mask_q && (level_i > {lim_hi, 1'b0});
    end

endmodule

// File: rtl/audio_rx_pack_fifo.sv
// Receive sample FIFO with word packing, level count and service request.
// Assumes: one pair per in_valid strobe; the reader honours level_o.
module audio_rx_pack_fifo
    import arxf_pkg::*;
#(
    parameter int PAIRS = 8,
    parameter int SW    = 32,
    localparam int CNT_W = $clog2(PAIRS + 1),
    localparam int LVL_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             in_valid,
    input  logic [SW-1:0]    in_left,
    input  logic [SW-1:0]    in_right,
    input  logic             rd_pop,
    output logic [31:0]      rd_data,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [LVL_W-1:0] level_o,
    output logic [LVL_W-1:0] limit_o,
    output logic             mask_o,
    output logic             svc_req,
    output logic             overflow
);

    rx_mode_e         mode;
    logic             half;
    logic             full;
    logic             empty;
    logic [CNT_W-1:0] cnt;
    logic [SW-1:0]    head_l;
    logic [SW-1:0]    head_r;
    logic             push_ok;
    logic             pop_evt;
    logic             pop_pair;
    logic             ovf_q;

    // Push, pop and drop qualification from the current state.
    always_comb begin
        push_ok  = rx_en && in_valid && !full;
        pop_evt  = rd_pop && !empty;
        pop_pair = pop_evt && ((mode != MD_DUAL) || half);
        level_o  = {cnt, 1'b0} - {{CNT_W{1'b0}}, half};
        overflow = ovf_q;
    end

    // Half-read tracking for dual mode and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (pop_evt)
                half <= (mode == MD_DUAL) ? !half : 1'b0;
            if (rx_en && in_valid && full)
                ovf_q <= 1'b1;
        end
    end

    arxf_pair_store #(.PAIRS(PAIRS), .SW(SW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_ok),
        .push_l_i (in_left),
        .push_r_i (in_right),
        .pop_i    (pop_pair),
        .head_l_o (head_l),
        .head_r_o (head_r),
        .cnt_o    (cnt),
        .full_o   (full),
        .empty_o  (empty)
    );

    arxf_packer #(.SW(SW)) u_pack (
        .mode_i   (mode),
        .half_i   (half),
        .empty_i  (empty),
        .head_l_i (head_l),
        .head_r_i (head_r),
        .data_o   (rd_data)
    );

    arxf_ctl #(.LVL_W(LVL_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .level_i   (level_o),
        .mode_o    (mode),
        .limit_o   (limit_o),
        .mask_o    (mask_o),
        .svc_o     (svc_req)
    );

endmodule

// File: rtl/arxf_checker.sv
// Port-level temporal checks for the audio receive FIFO, bound to the top.
module arxf_checker #(
    parameter int PAIRS = 8,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             in_valid,
    input logic             rd_pop,
    input logic [31:0]      rd_data,
    input logic [LVL_W-1:0] level_o,
    input logic [LVL_W-1:0] limit_o,
    input logic             mask_o,
    input logic             svc_req,
    input logic             overflow
);

    localparam logic [LVL_W-1:0] CAP = LVL_W'(2 * PAIRS);

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n) level_o <= CAP); // R5
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (level_o == '0) |-> (rd_data == '0)); // R9
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (level_o == '0 && rd_pop && !(rx_en && in_valid)) |=> (level_o == '0)); // R9
    AST_HIGH_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (limit_o >= CAP) |-> !svc_req); // R6
    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n) !mask_o |-> !svc_req); // R6
    AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!rx_en && !rd_pop) |=> $stable(level_o)); // R8
    AST_ENABLE_ARMS: assert property (@(posedge clk) disable iff (!rst_n) (rx_en && !$past(rx_en)) |=> mask_o); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R10
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (level_o == CAP && !rd_pop) |=> (level_o == CAP)); // R10

endmodule

bind audio_rx_pack_fifo arxf_checker #(.PAIRS(PAIRS), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .in_valid (in_valid),
    .rd_pop   (rd_pop),
    .rd_data  (rd_data),
    .level_o  (level_o),
    .limit_o  (limit_o),
    .mask_o   (mask_o),
    .svc_req  (svc_req),
    .overflow (overflow)
);

// File: tb/audio_rx_pack_fifo_tb.sv
`timescale 1ns/1ps
module audio_rx_pack_fifo_tb;

    localparam int PAIRS = 8;
    localparam int SW    = 32;
    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_en = 1'b0;
    logic             in_valid = 1'b0;
    logic [SW-1:0]    in_left = '0;
    logic [SW-1:0]    in_right = '0;
    logic             rd_pop = 1'b0;
    logic [31:0]      rd_data;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_sel = '0;
    logic [31:0]      reg_wdata = '0;
    logic [LVL_W-1:0] level_o;
    logic [LVL_W-1:0] limit_o;
    logic             mask_o;
    logic             svc_req;
    logic             overflow;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    audio_rx_pack_fifo #(.PAIRS(PAIRS), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .rd_pop(rd_pop), .rd_data(rd_data),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .level_o(level_o), .limit_o(limit_o), .mask_o(mask_o),
        .svc_req(svc_req), .overflow(overflow)
    );

    function automatic logic [31:0] lv(input int k);
        return 32'hC300_0000 ^ (32'(k) * 32'h0001_0203);
    endfunction
    function automatic logic [31:0] rv(input int k);
        return 32'h5A00_0000 ^ (32'(k) * 32'h0003_0507);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] l, input logic [31:0] r);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #(8ns * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] cfgw [4];
        logic [31:0] e;
        cfgw[0] = 32'hABC0_0002;   // bit1 only: dual (R11)
        cfgw[1] = 32'hABC0_0001;   // compact 16
        cfgw[2] = 32'hABC0_0003;   // compact 8
        cfgw[3] = 32'hABC0_0007;   // mono overrides (R11)

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R9 reset level", 32'(level_o), 0);
        chk("R9 reset data", rd_data, 0);
        chk("R7 reset limit", 32'(limit_o), 1);
        chk("R6 reset svc", 32'(svc_req), 0);
        chk("R10 reset ovf", 32'(overflow), 0);
        chk("R8 reset mask", 32'(mask_o), 0);

        // R8: disabled receiver ignores pairs
        push(32'h1111_1111, 32'h2222_2222);
        chk("R8 no capture off", 32'(level_o), 0);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R8 enable arms mask", 32'(mask_o), 1);

        // R9: empty read
        pop();
        chk("R9 empty pop level", 32'(level_o), 0);
        chk("R9 empty pop data", rd_data, 0);

        // Modes sweep
        for (int m = 0; m < 4; m++) begin
            wr(2'd0, cfgw[m]);
            for (int k = 0; k < PAIRS; k++) begin
                push(lv(m * 16 + k), rv(m * 16 + k));
                chk(m == 3 ? "R4 mono level" : "R5 level", 32'(level_o), 32'(2 * (k + 1)));
            end
            push(32'hDEAD_BEEF, 32'hFEED_F00D);
            chk("R10 full drop level", 32'(level_o), 16);
            chk("R10 overflow set", 32'(overflow), 1);
            for (int k = 0; k < PAIRS; k++) begin
                if (m == 0) begin
                    chk("R1 left first", rd_data, lv(k));
                    pop();
                    chk("R5 odd half level", 32'(level_o), 32'(16 - 2 * k - 1));
                    chk("R1 right second", rd_data, rv(k));
                    pop();
                end else begin
                    if (m == 1) e = {rv(16 + k)[15:0], lv(16 + k)[15:0]};
                    else if (m == 2) e = {16'h0, rv(32 + k)[7:0], lv(32 + k)[7:0]};
                    else e = lv(48 + k);
                    chk(m == 1 ? "R2 c16 word" : (m == 2 ? "R3 c8 word" : "R4 mono word"), rd_data, e);
                    pop();
                end
                chk("R5 level after read", 32'(level_o), 32'(16 - 2 * (k + 1)));
            end
            chk("R9 drained data", rd_data, 0);
        end
        chk("R10 overflow sticky", 32'(overflow), 1);

        // R6/R7: threshold sweep over every level and limit
        wr(2'd0, 32'h0);
        for (int k = 0; k < PAIRS; k++) push(lv(k), rv(k));
        for (int lev = 16; lev >= 0; lev--) begin
            for (int lim = 0; lim <= 16; lim += 2) begin
                wr(2'd1, 32'(lim) | 32'((lim / 2) % 2));
                chk("R7 limit readback", 32'(limit_o), 32'(lim | 1));
                chk("R6 svc compare", 32'(svc_req), 32'(lev > lim));
            end
            if (lev > 0) pop();
        end

        // R6: mask gating
        push(lv(5), rv(5));
        wr(2'd1, 32'h0);
        chk("R6 svc unmasked", 32'(svc_req), 1);
        wr(2'd2, 32'h0);
        chk("R6 svc masked", 32'(svc_req), 0);
        chk("R6 mask readback", 32'(mask_o), 0);

        // R8: disable, then re-enable re-arms mask
        rx_en = 1'b0;
        @(negedge clk);
        push(lv(6), rv(6));
        chk("R8 disabled ignores pair", 32'(level_o), 2);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R8 re-enable arms mask", 32'(mask_o), 1);
        chk("R6 svc rearmed", 32'(svc_req), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule